// File: doc/BRIEF.md
# Retry-Based Crossbar Cell Switch

This block moves fixed-length cells from N input ports to N output ports through a square matrix of crosspoints. Each arriving cell carries the index of its output port and one payload word. The cell is stored in a short per-input queue. An internal speedup splits every cell time into M transfer attempts of one clock each. In each attempt, the cell at the head of every input queue is driven onto its row towards the target column.

Conflicts are settled locally. A crosspoint whose own row is requesting takes the column and suppresses every row that lies upstream on that column. The winner is acknowledged in the same attempt, but only when the output queue of that column has a free entry. A head cell that gets no acknowledge is offered again in the next attempt, and again in later cell times if needed. An input that has been acknowledged stays silent until the next cell time begins. Each output queue hands out at most one cell per cell time over a valid/ready handshake. A cell that arrives at a full input queue is dropped and counted.

Top module: `cell_switch`

## Requirements
- R1: After reset, every out_valid is 0, every in_ready is 1 and every loss counter is 0.
- R2: A cell accepted at input i is delivered exactly once, with its payload intact, on the output port equal to its destination field (in_dest slice i, bit width $clog2(N)).
- R3: Cells from one input to one output leave in the order in which they were accepted.
- R4: When several inputs request the same output in one attempt, only the input with the highest index is acknowledged; the others retry in a later attempt.
- R5: An input is acknowledged at most once per cell time. After an acknowledge, its next head cell is not transferred before the next cell time, which starts every M cycles counted from the first clock after reset.
- R6: No acknowledge is given while the target output queue is full. The head cell stays queued and is transferred by retry once space appears, so no cell is lost behind a stalled output.
- R7: in_ready[i] is 0 exactly when input queue i holds IQ_DEPTH cells. An arrival offered while in_ready[i] is 0 is dropped, and loss_count slice i increases by one.
- R8: Each output queue holds up to OQ_DEPTH cells. With all outputs stalled and all traffic aimed at one output, exactly OQ_DEPTH + N*IQ_DEPTH cells are accepted.
- R9: Each output port completes at most one handshake per cell time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one transfer attempt per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N | Per-input arrival strobe |
| in_ready | output | N | Per-input queue has space |
| in_dest | input | N*$clog2(N) | Per-input destination port index |
| in_data | input | N*PW | Per-input payload word |
| out_valid | output | N | Per-output cell available this cell time |
| out_ready | input | N | Per-output sink accepts the cell |
| out_data | output | N*PW | Per-output payload word |
| loss_count | output | N*LW | Per-input count of dropped arrivals |

## Verification
Two events can fall in the same attempt: a column conflict at the crosspoints, and a full output queue on that same column. When both happen, neither the winner nor the loser may be acknowledged. A second pair is an arrival at a full input queue in the cycle its head is acknowledged. The stimulus provokes both pairs by alternating phases of uniform and hotspot destinations while out_ready is randomly held low. The result is judged at the ports: every accepted cell must appear exactly once and in order, each rejected arrival must never appear, and the loss counters must equal the rejected arrivals the bench observed through in_ready.

// File: rtl/cellsw_pkg.sv
// Shared defaults for the retry crossbar cell switch.
// Assumes: consumers take these as parameter defaults only.
package cellsw_pkg;
    localparam int N_PORTS_DEF   = 4;   // ports per side
    localparam int SPEEDUP_DEF   = 4;   // attempts per cell time
    localparam int IQ_DEPTH_DEF  = 10;  // cells per input queue
    localparam int OQ_DEPTH_DEF  = 50;  // cells per output queue
    localparam int PAYLOAD_W_DEF = 16;  // payload word width
    localparam int LOSS_W_DEF    = 16;  // loss counter width
endpackage

// File: rtl/cell_timer.sv
// Cell-time sequencer: counts M attempt slots and flags the last slot.
// Assumes: M >= 2; slot 0 is the first clock after reset release.
module cell_timer #(
    parameter int M = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic cell_end
);
    localparam int SW = (M > 1) ? $clog2(M) : 1;

    logic [SW-1:0] slot_q;

    assign cell_end = (slot_q == SW'(M - 1));

    // Advance the attempt slot, wrapping at the end of each cell time.
    always_ff @(posedge clk) begin
        if (!rst_n)        slot_q <= '0;
        else if (cell_end) slot_q <= '0;
        else               slot_q <= slot_q + 1'b1;
    end
endmodule

// File: rtl/cell_fifo.sv
// Circular cell queue of any depth, with registered storage.
// Assumes: a push when full and a pop when empty are ignored; the
// head word is valid whenever empty is low.
module cell_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Write the arriving word into the tail slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/xpoint_matrix.sv
// Crosspoint matrix: each column carries a claim line. A row that
// requests a column takes it and masks all rows upstream of it, so the
// highest-index requesting row wins. Purely combinational.
// Assumes: each row requests at most one column.
module xpoint_matrix #(
    parameter int N = 4
) (
    input  logic [N-1:0] req [N],
    output logic [N-1:0] win [N]
);
    logic [N-1:0] claim [N+1];

    assign claim[N] = '0;

    for (genvar i = N - 1; i >= 0; i--) begin : g_row
        assign claim[i] = claim[i+1] | req[i];
        assign win[i]   = req[i] & ~claim[i+1];
    end
endmodule

// File: rtl/cell_switch.sv
// Retry crossbar cell switch: input queues offer head cells into a
// crosspoint matrix once per attempt, M attempts per cell time. A head
// cell is popped only when its column is won and the output queue has
// room. Output queues release at most one cell per cell time.
// Assumes: N >= 2, M >= 2; destination is the upper field of a cell.
module cell_switch
    import cellsw_pkg::*;
#(
    parameter int N        = N_PORTS_DEF,
    parameter int M        = SPEEDUP_DEF,
    parameter int IQ_DEPTH = IQ_DEPTH_DEF,
    parameter int OQ_DEPTH = OQ_DEPTH_DEF,
    parameter int PW       = PAYLOAD_W_DEF,
    parameter int LW       = LOSS_W_DEF,
    localparam int DW      = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_valid,
    output logic [N-1:0]    in_ready,
    input  logic [N*DW-1:0] in_dest,
    input  logic [N*PW-1:0] in_data,
    output logic [N-1:0]    out_valid,
    input  logic [N-1:0]    out_ready,
    output logic [N*PW-1:0] out_data,
    output logic [N*LW-1:0] loss_count
);
    localparam int CELL_W = DW + PW;

    logic              cell_end;
    logic [CELL_W-1:0] iq_head [N];
    logic [N-1:0]      iq_empty, iq_full, ack, oq_full, oq_empty, oq_push;
    logic [N-1:0]      req [N];
    logic [N-1:0]      win [N];
    logic [N*N-1:0]    win_flat;

    cell_timer #(.M(M)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_end (cell_end)
    );

    xpoint_matrix #(.N(N)) u_xp (
        .req (req),
        .win (win)
    );

    for (genvar i = 0; i < N; i++) begin : g_in
        logic          sent_q;
        logic [LW-1:0] loss_q;

        cell_fifo #(.W(CELL_W), .DEPTH(IQ_DEPTH)) u_iq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i]),
            .wdata ({in_dest[i*DW +: DW], in_data[i*PW +: PW]}),
            .pop   (ack[i]),
            .rdata (iq_head[i]),
            .empty (iq_empty[i]),
            .full  (iq_full[i])
        );

        assign in_ready[i] = ~iq_full[i];
        assign req[i]      = (!iq_empty[i] && !sent_q)
                           ? (N'(1) << iq_head[i][CELL_W-1 -: DW]) : '0;
        assign ack[i]      = |(win[i] & ~oq_full);
        assign win_flat[i*N +: N]       = win[i];
        assign loss_count[i*LW +: LW]   = loss_q;

        // Hold the input silent for the rest of a cell time after an acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        sent_q <= 1'b0;
            else if (cell_end) sent_q <= 1'b0;
            else if (ack[i])   sent_q <= 1'b1;
        end

        // Count arrivals rejected by a full input queue.
        always_ff @(posedge clk) begin
            if (!rst_n)                      loss_q <= '0;
            else if (in_valid[i] && iq_full[i]) loss_q <= loss_q + 1'b1;
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        logic          col_any, credit_q, pop_j;
        logic [PW-1:0] col_data;

        // Gather the winning row's payload onto this column.
        always_comb begin
            col_any  = 1'b0;
            col_data = '0;
            for (int i = 0; i < N; i++) begin
                if (win[i][j]) begin
                    col_any  = 1'b1;
                    col_data = iq_head[i][PW-1:0];
                end
            end
        end

        assign oq_push[j]   = col_any & ~oq_full[j];
        assign out_valid[j] = ~oq_empty[j] & credit_q;
        assign pop_j        = out_valid[j] & out_ready[j];

        cell_fifo #(.W(PW), .DEPTH(OQ_DEPTH)) u_oq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (oq_push[j]),
            .wdata (col_data),
            .pop   (pop_j),
            .rdata (out_data[j*PW +: PW]),
            .empty (oq_empty[j]),
            .full  (oq_full[j])
        );

        // Grant one output handshake per cell time.
        always_ff @(posedge clk) begin
            if (!rst_n)        credit_q <= 1'b1;
            else if (cell_end) credit_q <= 1'b1;
            else if (pop_j)    credit_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cell_switch_chk.sv
// Property checker for cell_switch, attached by bind below.
// Assumes: signals are sampled on the switch clock.
module cell_switch_chk #(
    parameter int N  = 4,
    parameter int LW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cell_end,
    input logic [N-1:0]    ack,
    input logic [N-1:0]    oq_push,
    input logic [N*N-1:0]  win_flat,
    input logic [N-1:0]    in_valid,
    input logic [N-1:0]    in_ready,
    input logic [N*LW-1:0] loss_count,
    input logic [N-1:0]    out_valid,
    input logic [N-1:0]    out_ready
);
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_valid == '0 && loss_count == '0));

    // R2: every acknowledge lands as exactly one output queue write.
    p_ack_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ack) == $countones(oq_push));

    for (genvar i = 0; i < N; i++) begin : g_in
        logic acked_q;

        // Track whether this input was already acknowledged this cell time.
        always_ff @(posedge clk) begin
            if (!rst_n)        acked_q <= 1'b0;
            else if (cell_end) acked_q <= 1'b0;
            else if (ack[i])   acked_q <= 1'b1;
        end

        p_one_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ack[i] |-> !acked_q);

        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && !in_ready[i]) |=>
            (loss_count[i*LW +: LW] == $past(loss_count[i*LW +: LW]) + LW'(1)));
    end

    for (genvar j = 0; j < N; j++) begin : g_col
        logic [N-1:0] col_w;
        logic         drained_q;
        logic         pop_j;

        for (genvar i = 0; i < N; i++) begin : g_bit
            assign col_w[i] = win_flat[i*N + j];
        end
        assign pop_j = out_valid[j] & out_ready[j];

        // Track whether this output already handed out a cell this cell time.
        always_ff @(posedge clk) begin
            if (!rst_n)        drained_q <= 1'b0;
            else if (cell_end) drained_q <= 1'b0;
            else if (pop_j)    drained_q <= 1'b1;
        end

        p_col_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_w));

        p_one_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pop_j |-> !drained_q);
    end
endmodule

bind cell_switch cell_switch_chk #(.N(N), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_end   (cell_end),
    .ack        (ack),
    .oq_push    (oq_push),
    .win_flat   (win_flat),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .loss_count (loss_count),
    .out_valid  (out_valid),
    .out_ready  (out_ready)
);

// File: tb/cell_switch_tb.sv
// Bench for cell_switch: directed corner cases, then seeded random
// traffic with hotspot phases, judged by a port-level scoreboard.
module cell_switch_tb;
    localparam int N = 4, M = 4, PW = 16, LW = 16, DW = 2;
    localparam int IQD = 10, OQD = 50;

    logic            clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0, out_ready = '0;
    logic [N*DW-1:0] in_dest = '0;
    logic [N*PW-1:0] in_data = '0;
    logic [N-1:0]    in_ready, out_valid;
    logic [N*PW-1:0] out_data;
    logic [N*LW-1:0] loss_count;

    int checks = 0, errors = 0, cyc = 0;
    bit acc [N][1024];
    bit dlv [N][1024];
    int nseq [N], drops [N], acc_cnt [N];
    int last_seq [N][N];
    int hs_win [N], hs_cyc [N];
    logic [PW-1:0] dq [N][$];
    bit done = 1'b0;

    cell_switch #(.N(N), .M(M), .IQ_DEPTH(IQD), .OQ_DEPTH(OQD), .PW(PW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .loss_count(loss_count)
    );

    always #2 clk = ~clk;

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int loss_of(int i);
        return int'(loss_count[i*LW +: LW]);
    endfunction

    task automatic offer(int s, int d);
        in_valid[s] = 1'b1;
        in_dest[s*DW +: DW] = d[1:0];
        in_data[s*PW +: PW] = {s[1:0], d[1:0], 2'b00, nseq[s][9:0]};
        nseq[s]++;
    endtask

    task automatic wait_phase(int ph);
        do @(negedge clk); while (cyc % M != ph);
    endtask

    // Monitor: sample half a phase before each rising edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (in_valid[i]) begin
                    if (in_ready[i]) begin
                        acc[i][in_data[i*PW +: 10]] = 1'b1;
                        acc_cnt[i]++;
                    end else drops[i]++;
                end
            end
            for (int j = 0; j < N; j++) begin
                if (out_valid[j] && out_ready[j]) begin
                    logic [PW-1:0] pl;
                    int s, d, q;
                    pl = out_data[j*PW +: PW];
                    s = int'(pl[15:14]); d = int'(pl[13:12]); q = int'(pl[9:0]);
                    chk(d == j, "R2", "output port", j, d);
                    chk(acc[s][q] && !dlv[s][q], "R2", "accepted and not yet delivered",
                        int'(dlv[s][q]), 0);
                    dlv[s][q] = 1'b1;
                    chk(q > last_seq[s][j], "R3", "sequence order", q, last_seq[s][j] + 1);
                    last_seq[s][j] = q;
                    chk(hs_win[j] != cyc / M, "R9", "handshakes in cell time", 2, 1);
                    hs_win[j] = cyc / M;
                    hs_cyc[j] = cyc;
                    dq[j].push_back(pl);
                end
            end
            cyc++;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WD", "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        int base_acc, base_drop, base_dq;
        void'($urandom(32'd2718));
        for (int i = 0; i < N; i++) begin
            nseq[i] = 0; drops[i] = 0; acc_cnt[i] = 0; hs_win[i] = -1; hs_cyc[i] = 0;
            for (int j = 0; j < N; j++) last_seq[i][j] = -1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports.
        chk(out_valid == '0, "R1", "out_valid", int'(out_valid), 0);
        chk(in_ready == '1, "R1", "in_ready", int'(in_ready), 15);
        chk(loss_count == '0, "R1", "loss_count", int'(loss_count != '0), 0);
        @(negedge clk);
        out_ready = '1;
        repeat (8) @(negedge clk);

        // R4: inputs 1 and 3 collide on output 2; input 3 must go first.
        offer(1, 2); offer(3, 2);
        @(negedge clk); in_valid = '0;
        repeat (40) @(negedge clk);
        chk(dq[2].size() == 2, "R4", "cells on output 2", dq[2].size(), 2);
        if (dq[2].size() == 2) begin
            chk(dq[2][0][15:14] == 2'd3, "R4", "first source", int'(dq[2][0][15:14]), 3);
            chk(dq[2][1][15:14] == 2'd1, "R4", "second source", int'(dq[2][1][15:14]), 1);
        end

        // R5: two cells from input 0 to idle outputs 0 and 1, first acked in slot 0.
        wait_phase(M - 1);
        offer(0, 0);
        @(negedge clk); in_valid = '0; offer(0, 1);
        @(negedge clk); in_valid = '0;
        repeat (30) @(negedge clk);
        chk(hs_cyc[1] - hs_cyc[0] == M, "R5", "gap between transfers", hs_cyc[1] - hs_cyc[0], M);

        // R6, R7, R8: all outputs stalled, every input aims at output 0.
        out_ready = '0;
        base_acc = 0; base_drop = 0;
        for (int i = 0; i < N; i++) begin
            base_acc += acc_cnt[i]; base_drop += drops[i];
        end
        base_dq = dq[0].size();
        for (int c = 0; c < 30; c++) begin
            wait_phase(0);
            for (int i = 0; i < N; i++) offer(i, 0);
            @(negedge clk); in_valid = '0;
        end
        repeat (20) @(negedge clk);
        begin
            int a, d;
            a = -base_acc; d = -base_drop;
            for (int i = 0; i < N; i++) begin
                a += acc_cnt[i]; d += drops[i];
            end
            chk(a == OQD + N * IQD, "R8", "cells held while stalled", a, OQD + N * IQD);
            chk(d == 30 * N - (OQD + N * IQD), "R7", "arrivals dropped", d, 30 * N - (OQD + N * IQD));
            chk(in_ready == '0, "R7", "in_ready with full queues", int'(in_ready), 0);
            for (int i = 0; i < N; i++)
                chk(loss_of(i) == drops[i], "R7", "loss counter", loss_of(i), drops[i]);
        end
        out_ready = '1;
        repeat ((OQD + N * IQD) * M + 100) @(negedge clk);
        chk(dq[0].size() - base_dq == OQD + N * IQD, "R6", "cells released after stall",
            dq[0].size() - base_dq, OQD + N * IQD);

        // Random traffic, alternating uniform and hotspot phases.
        for (int c = 0; c < 1500; c++) begin
            bit hot;
            hot = ((c / 200) % 2) == 1;
            for (int t = 0; t < M; t++) begin
                @(negedge clk);
                for (int i = 0; i < N; i++) begin
                    in_valid[i] = 1'b0;
                    if ((cyc % M == i % M) && ($urandom % 2 == 1))
                        offer(i, hot ? 0 : int'($urandom % N));
                    out_ready[i] = ($urandom % 4) != 0;
                end
            end
        end
        @(negedge clk);
        in_valid = '0; out_ready = '1;
        repeat (3000) @(negedge clk);

        // R2, R7: final accounting.
        for (int s = 0; s < N; s++) begin
            for (int q = 0; q < nseq[s]; q++)
                if (acc[s][q]) chk(dlv[s][q], "R2", "accepted cell delivered", 0, 1);
            chk(loss_of(s) == drops[s], "R7", "final loss counter", loss_of(s), drops[s]);
        end
        done = 1'b1;
        summary();
    end
endmodule